// File: doc/BRIEF.md
# Performance Counter Bank with Central Freeze

This block holds a small set of general-purpose event counters that share one control and status area. Each counter accepts a per-cycle increment request from event-filtering logic outside the block. Whether a counter actually advances depends on three things: its enable bit, the external freeze input, and whether software is writing that counter in the same cycle. None of the counters is tied to a privilege level. Because all enable bits sit in one central register, a single write can start or stop every counter at the same moment.

Each enable bit can also be reached through a small per-counter control view. Both paths reach the same storage bit, so a write through either one is seen by the other. A counter overflows when its most significant bit goes from 0 to 1 through an increment. The whole count therefore remains a plain unsigned value. Each counter has a sticky status bit that records its overflow. The status bits are cleared by writing 1 to them. All counters share one level interrupt, which is gated by per-counter interrupt enables.

Registers are reached through a simple write strobe with address and data, and a combinational read port. Address bits [5:4] select the area: 00 is the shared registers, 01 is the per-counter control views, and 10 is the counter values. Bits [3:0] select the register or the counter index.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, all counters, enable bits, interrupt enable bits and status bits read as zero, and `irq_o` is low.
- R2: A counter advances by exactly 1 in a cycle where its `inc_i` bit is high, its enable bit is set, `freeze_i` is low and software is not writing that counter. Otherwise the counter holds its value. The count wraps from all ones to zero.
- R3: The central enable register is at address 0x00, and bit i enables counter i. A single write replaces all enable bits at once.
- R4: The control view of counter i is at address 0x10+i. Bit 0 is the same storage bit as central enable bit i, and bit 1 is the same storage bit as interrupt enable bit i. A write through a view is visible through the central registers, and the reverse also holds.
- R5: While `freeze_i` is high, no counter advances, whatever its enable bit says.
- R6: An increment from 0x7FFF to 0x8000 (top bit rising, 16-bit counter) sets status bit i at address 0x01. A wrap from 0xFFFF to 0x0000 does not set it, and neither does a software write of a value with the top bit set.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An overflow in the same cycle as a clear leaves the bit set.
- R8: `irq_o` is high whenever some status bit and its interrupt enable bit are both set. It stays high until the status bit is cleared or its interrupt enable bit is cleared.
- R9: The value of counter i is at address 0x20+i and can be read and written. A write to a counter takes priority over an increment in the same cycle.
- R10: The interrupt enable register is at address 0x02, with bit i belonging to counter i.
- R11: Addresses outside the map read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | External freeze; while it is high, no counter advances |
| inc_i | input | N_CTR | Per-counter increment request from the event filters |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write address |
| wr_data_i | input | CTR_W | Write data |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | CTR_W | Combinational read data |
| irq_o | output | 1 | Combined overflow interrupt (level) |

## Verification
Several properties guard only the cycles in which no register write is in progress. Examples are the properties that a disabled or frozen counter holds and that a status bit stays set. These properties assume that any change not explained by an increment comes from the write port. The bench drives a write in only about a quarter of its random cycles, so these properties stay active for most of the run. The random writes target mapped addresses, and the counter loads are biased to values just below 0x7FFF and 0xFFFF. This biasing makes overflows, wraps and simultaneous set-and-clear cases occur often. Freeze is raised in about one random cycle in eight, and directed cases cover the alias, priority and unmapped-address behaviour.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int ADDR_W    = 6;
    localparam int MAX_CTR   = 16;
    localparam int VIEW_EN_B = 0;
    localparam int VIEW_IE_B = 1;

    typedef enum logic [1:0] {
        REGION_SHARED = 2'b00,
        REGION_VIEW   = 2'b01,
        REGION_COUNT  = 2'b10,
        REGION_NONE   = 2'b11
    } region_e;

    localparam logic [3:0] OFS_ENABLE = 4'h0;
    localparam logic [3:0] OFS_STATUS = 4'h1;
    localparam logic [3:0] OFS_IRQEN  = 4'h2;

    typedef struct packed {
        region_e    region;
        logic [3:0] idx;
    } decode_t;

    typedef struct packed {
        logic adv;
        logic ld;
    } ctr_cmd_t;

    function automatic decode_t pcb_decode(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.region = region_e'(a[5:4]);
        d.idx    = a[3:0];
        return d;
    endfunction

    function automatic logic shared_hit(input decode_t d, input logic [3:0] ofs);
        return (d.region == REGION_SHARED) && (d.idx == ofs);
    endfunction

endpackage

// File: rtl/pcb_ctrl_regs.sv
module pcb_ctrl_regs
    import pcb_pkg::*;
#(
    parameter int N_CTR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  decode_t          wr_dec,
    input  logic [N_CTR-1:0] wr_bits,
    output logic [N_CTR-1:0] en_q,
    output logic [N_CTR-1:0] ie_q
);
    localparam int IDX_W = $clog2(N_CTR);

    logic central_en_wr;
    logic central_ie_wr;
    logic view_wr;
    logic [IDX_W-1:0] vidx;

    assign central_en_wr = wr_en && shared_hit(wr_dec, OFS_ENABLE);
    assign central_ie_wr = wr_en && shared_hit(wr_dec, OFS_IRQEN);
    assign view_wr       = wr_en && (wr_dec.region == REGION_VIEW)
                           && (int'(wr_dec.idx) < N_CTR);
    assign vidx          = wr_dec.idx[IDX_W-1:0];

    // One storage bit per counter; the central write is applied last so it wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            ie_q <= '0;
        end else begin
            if (view_wr) begin
                en_q[vidx] <= wr_bits[VIEW_EN_B];
                ie_q[vidx] <= wr_bits[VIEW_IE_B];
            end
            if (central_en_wr) en_q <= wr_bits;
            if (central_ie_wr) ie_q <= wr_bits;
        end
    end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
    import pcb_pkg::*;
#(
    parameter int CTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_cmd_t         cmd,
    input  logic [CTR_W-1:0] ld_val,
    output logic [CTR_W-1:0] cnt_q,
    output logic             ovf_evt
);
    localparam logic [CTR_W-1:0] BELOW_TOP = {1'b0, {(CTR_W-1){1'b1}}};

    // Top bit rises only on the step out of the value just below half range.
    assign ovf_evt = cmd.adv && !cmd.ld && (cnt_q == BELOW_TOP);

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (cmd.ld)  cnt_q <= ld_val;
        else if (cmd.adv) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
    parameter int N_CTR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CTR-1:0] set_i,
    input  logic [N_CTR-1:0] clr_i,
    input  logic [N_CTR-1:0] ie_i,
    output logic [N_CTR-1:0] st_q,
    output logic             irq_o
);
    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= (st_q & ~clr_i) | set_i;
    end

    assign irq_o = |(st_q & ie_i);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
    import pcb_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int CTR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 freeze_i,
    input  logic [N_CTR-1:0]     inc_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [CTR_W-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [CTR_W-1:0]     rd_data_o,
    output logic                 irq_o
);
    localparam int IDX_W = $clog2(N_CTR);

    decode_t wr_dec;
    decode_t rd_dec;
    logic [N_CTR-1:0]       en_q;
    logic [N_CTR-1:0]       ie_q;
    logic [N_CTR-1:0]       st_q;
    logic [N_CTR-1:0]       ovf_evt;
    logic [N_CTR-1:0]       st_clr;
    logic [CTR_W-1:0]       cnt [N_CTR];
    logic [N_CTR*CTR_W-1:0] cnt_flat;

    assign wr_dec = pcb_decode(wr_addr_i);
    assign rd_dec = pcb_decode(rd_addr_i);

    pcb_ctrl_regs #(.N_CTR(N_CTR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_dec  (wr_dec),
        .wr_bits (wr_data_i[N_CTR-1:0]),
        .en_q    (en_q),
        .ie_q    (ie_q)
    );

    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
        ctr_cmd_t cmd;
        assign cmd.ld  = wr_en_i && (wr_dec.region == REGION_COUNT) && (wr_dec.idx == 4'(i));
        assign cmd.adv = inc_i[i] && en_q[i] && !freeze_i;

        pcb_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd),
            .ld_val  (wr_data_i),
            .cnt_q   (cnt[i]),
            .ovf_evt (ovf_evt[i])
        );
        assign cnt_flat[i*CTR_W +: CTR_W] = cnt[i];
    end

    assign st_clr = (wr_en_i && shared_hit(wr_dec, OFS_STATUS)) ? wr_data_i[N_CTR-1:0] : '0;

    pcb_status #(.N_CTR(N_CTR)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (ovf_evt),
        .clr_i (st_clr),
        .ie_i  (ie_q),
        .st_q  (st_q),
        .irq_o (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (rd_dec.region)
            REGION_SHARED: begin
                if (rd_dec.idx == OFS_ENABLE)      rd_data_o[N_CTR-1:0] = en_q;
                else if (rd_dec.idx == OFS_STATUS) rd_data_o[N_CTR-1:0] = st_q;
                else if (rd_dec.idx == OFS_IRQEN)  rd_data_o[N_CTR-1:0] = ie_q;
            end
            REGION_VIEW: begin
                if (int'(rd_dec.idx) < N_CTR) begin
                    rd_data_o[VIEW_EN_B] = en_q[rd_dec.idx[IDX_W-1:0]];
                    rd_data_o[VIEW_IE_B] = ie_q[rd_dec.idx[IDX_W-1:0]];
                end
            end
            REGION_COUNT: begin
                if (int'(rd_dec.idx) < N_CTR) rd_data_o = cnt[rd_dec.idx[IDX_W-1:0]];
            end
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int N_CTR = 4,
    parameter int CTR_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   freeze_i,
    input logic [N_CTR-1:0]       inc_i,
    input logic                   wr_en_i,
    input logic [N_CTR-1:0]       en,
    input logic [N_CTR-1:0]       ie,
    input logic [N_CTR-1:0]       st,
    input logic [N_CTR*CTR_W-1:0] cnt_flat,
    input logic [N_CTR-1:0]       ovf_evt,
    input logic                   irq_o
);
    // R5: a frozen bank with no write holds every count.
    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && !wr_en_i) |=> $stable(cnt_flat));

    for (genvar i = 0; i < N_CTR; i++) begin : g_chk
        // R2: a disabled counter does not move without a write.
        p_disabled_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!wr_en_i && !en[i]) |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

        // R2: an accepted increment adds exactly one.
        p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
            (!wr_en_i && en[i] && inc_i[i] && !freeze_i)
            |=> (cnt_flat[i*CTR_W +: CTR_W] == $past(cnt_flat[i*CTR_W +: CTR_W]) + 1'b1));

        // R6/R7: an overflow event always leaves the status bit set.
        p_overflow_sets_r6: assert property (@(posedge clk) disable iff (rst)
            ovf_evt[i] |=> st[i]);

        // R7: without a write the status bit cannot drop.
        p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (st[i] && !wr_en_i) |=> st[i]);

        // R8: an enabled overflow raises the interrupt next cycle.
        p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
            (ovf_evt[i] && ie[i] && !wr_en_i) |=> irq_o);
    end
endmodule

bind perf_ctr_bank pcb_checker #(.N_CTR(N_CTR), .CTR_W(CTR_W)) u_pcb_checker (
    .clk      (clk),
    .rst      (rst),
    .freeze_i (freeze_i),
    .inc_i    (inc_i),
    .wr_en_i  (wr_en_i),
    .en       (en_q),
    .ie       (ie_q),
    .st       (st_q),
    .cnt_flat (cnt_flat),
    .ovf_evt  (ovf_evt),
    .irq_o    (irq_o)
);

// File: tb/perf_ctr_bank_bench.sv
`timescale 1ns/1ps
module perf_ctr_bank_bench;
    localparam int N = 4;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         freeze = 1'b0;
    logic [N-1:0] inc = '0;
    logic         we = 1'b0;
    logic [5:0]   wa = '0;
    logic [W-1:0] wd = '0;
    logic [5:0]   ra = '0;
    logic [W-1:0] rd;
    logic         irq;

    always #2.5 clk = ~clk;

    perf_ctr_bank #(.N_CTR(N), .CTR_W(W)) u_perf_ctr_bank (
        .clk(clk), .rst(rst), .freeze_i(freeze), .inc_i(inc),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
    );

    logic [W-1:0] m_cnt [N];
    logic [N-1:0] m_en, m_ie, m_st;
    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_read(logic [5:0] a);
        logic [W-1:0] r = '0;
        if (a == 6'h00) r[N-1:0] = m_en;
        else if (a == 6'h01) r[N-1:0] = m_st;
        else if (a == 6'h02) r[N-1:0] = m_ie;
        else if (a[5:4] == 2'b01 && int'(a[3:0]) < N) r = {14'b0, m_ie[a[1:0]], m_en[a[1:0]]};
        else if (a[5:4] == 2'b10 && int'(a[3:0]) < N) r = m_cnt[a[1:0]];
        return r;
    endfunction

    task automatic rd_chk(string req, logic [5:0] a);
        ra = a;
        #0.1;
        chk(req, rd, exp_read(a));
    endtask

    task automatic check_all(string req);
        rd_chk(req, 6'h00);
        rd_chk(req, 6'h01);
        rd_chk(req, 6'h02);
        for (int i = 0; i < N; i++) begin
            rd_chk(req, 6'h10 + 6'(i));
            rd_chk(req, 6'h20 + 6'(i));
        end
        chk({req, " R8 irq"}, {15'b0, irq}, {15'b0, |(m_st & m_ie)});
    endtask

    // Drive one cycle of stimulus and update the reference model at the edge.
    task automatic step(logic [N-1:0] i_v, logic f, logic w, logic [5:0] a, logic [W-1:0] d);
        logic [N-1:0] ovf = '0;
        logic [N-1:0] clr;
        inc = i_v; freeze = f; we = w; wa = a; wd = d;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (w && a == 6'h20 + 6'(i)) m_cnt[i] = d;
            else if (i_v[i] && m_en[i] && !f) begin
                if (m_cnt[i] == 16'h7FFF) ovf[i] = 1'b1;
                m_cnt[i] = m_cnt[i] + 1'b1;
            end
        end
        clr  = (w && a == 6'h01) ? d[N-1:0] : '0;
        m_st = (m_st & ~clr) | ovf;
        for (int i = 0; i < N; i++)
            if (w && a == 6'h10 + 6'(i)) begin m_en[i] = d[0]; m_ie[i] = d[1]; end
        if (w && a == 6'h00) m_en = d[N-1:0];
        if (w && a == 6'h02) m_ie = d[N-1:0];
        @(negedge clk);
        inc = '0; freeze = 1'b0; we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        logic [5:0] a;
        logic [W-1:0] d;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        m_en = '0; m_ie = '0; m_st = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        step('1, 0, 1, 6'h00, 16'h000F);          // R3 one write enables all
        check_all("R3 central enable");
        repeat (3) step('1, 0, 0, 0, 0);
        check_all("R2 three increments");

        step('1, 0, 1, 6'h12, 16'h0000);          // R4 disable counter 2 by its view
        rd_chk("R4 view write seen centrally", 6'h00);
        step('1, 0, 1, 6'h11, 16'h0003);
        rd_chk("R10 view write seen in irq enable reg", 6'h02);
        check_all("R4 alias");

        step('1, 1, 0, 0, 0);
        step('1, 1, 0, 0, 0);
        check_all("R5 freeze holds");

        step(4'b0001, 0, 1, 6'h20, 16'h7FFE);     // R9 write beats increment
        check_all("R9 write priority");
        step(4'b0001, 0, 0, 0, 0);
        rd_chk("R6 no flag at 0x7FFF", 6'h01);
        step(4'b0001, 0, 0, 0, 0);
        check_all("R6 overflow to 0x8000");
        step('0, 0, 1, 6'h02, 16'h0003);
        check_all("R8 irq on enable");

        step('0, 0, 1, 6'h21, 16'hFFFF);
        step(4'b0010, 0, 0, 0, 0);
        check_all("R6 wrap sets nothing");
        step('0, 0, 1, 6'h23, 16'h8000);
        check_all("R6 load sets nothing");

        step('0, 0, 1, 6'h01, 16'h0000);
        check_all("R7 write zero keeps");
        step('0, 0, 1, 6'h01, 16'h0001);
        check_all("R7 write one clears, R8 irq falls");
        step('0, 0, 1, 6'h20, 16'h7FFF);
        step(4'b0001, 0, 1, 6'h01, 16'h000F);
        check_all("R7 set beats clear");

        step('0, 0, 1, 6'h3F, 16'hFFFF);
        step('0, 0, 1, 6'h07, 16'hFFFF);
        rd_chk("R11 unmapped read", 6'h3F);
        rd_chk("R11 unmapped read", 6'h07);
        check_all("R11 unmapped write ignored");

        for (int n = 0; n < 3000; n++) begin
            logic w  = ($urandom % 4) == 0;
            logic f  = ($urandom % 8) == 0;
            int  sel = $urandom % 5;
            d = 16'($urandom);
            case (sel)
                0: a = 6'h00;
                1: a = 6'h01;
                2: a = 6'h02;
                3: a = 6'h10 + 6'($urandom % N);
                default: begin
                    a = 6'h20 + 6'($urandom % N);
                    if ($urandom % 2) d = (($urandom % 2) ? 16'h7FFC : 16'hFFFC) + 16'($urandom % 4);
                end
            endcase
            step(4'($urandom), f, w, a, d);
            check_all("R2 random");
        end
        finish_run();
    end
endmodule